// File: doc/BRIEF.md
# Register-programmed SPI master controller

This block is an SPI master that software runs through eight word-wide registers on a simple single-cycle write/read port. Software sets the clock polarity, clock phase, bit order, word size and clock divider. It turns on receive and transmit, and it turns on the mode in which a transmit write launches a transfer. Each word written to the transmit queue is then shifted out on MOSI, and the word captured from MISO during the same frame lands in the receive queue.

Software selects a slave through one register. That register holds an output-enable bit and a level bit for each of seven active-low select lines. To assert a line, software enables it and clears its level bit. A sticky status flag reports that a word has finished. Software polls it, then pulls the received word. Software clears the flag by writing ones to it.

Register offsets on the 3-bit word address are: 0 control, 1 divider, 2 slave select, 3 status, 4 receive control, 5 transmit control, 6 transmit data (write), 7 receive data (read, pops).

Top module: `spi_reg_master`

## Requirements
- R1: After reset the slave-select register reads 0x0000FE00, every ss_no line is high, ss_oe_o is zero, status reads 0x1 (receive empty only), and sclk_o is low.
- R2: One SCLK period lasts (divider + 1) system clocks, and a divider of 0 is treated as 1. While no word is in flight, sclk_o rests at the polarity bit, control bit 2.
- R3: A word leaves the transmit queue only when all of these are set: control bit 0 (enable), control bit 1 (master), receive control bit 0 (receive on), transmit control bit 0 (transmit on) and transmit control bit 1 (write launches transfer). Otherwise queued words stay put and no transfer occurs.
- R4: Control bits [6:5] set the word size: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Only the low bits of a transmit word are sent, and received words are zero-extended.
- R5: Bits go out most-significant first, unless control bit 4 is set, in which case they go out least-significant first.
- R6: Control bit 3 is the phase. When it is 0, MISO is sampled on the first SCLK edge of each bit and MOSI changes on the second. When it is 1, MOSI changes on the first edge and MISO is sampled on the second.
- R7: Each finished word is pushed into a 4-entry receive queue. A read of offset 7 returns and removes the oldest entry. A read of offset 7 when the queue is empty returns zero.
- R8: Status bit 0 is high while the receive queue is empty. Status bit 1 is set when a word finishes and stays set until a status write with bit 1 at one. Each status bit is cleared only by writing a one to its own position.
- R9: The transmit queue holds 4 words, sent in order. A write to offset 6 while the queue is full is dropped and sets sticky status bit 2.
- R10: Slave-select bits [7:1] drive ss_oe_o[6:0], and bits [15:9] give the level driven on ss_no[6:0]. A line whose enable bit is clear is driven high whatever its level bit holds.
- R11: Clearing control bit 0 in the middle of a word aborts it. SCLK returns to its rest level, and no word is pushed or flagged as finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive queue at offset 7) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 7 | Active-low slave selects |
| ss_oe_o | output | 7 | Output enables for the slave selects |

## Verification
The assertions assume three things about the register port. A strobe is held for one clock. The word size, polarity and phase fields are not rewritten while a word is in flight, except when the enable bit is cleared to abort it. MISO is stable around the sampling edge. The bench programs every mode field before it writes the transmit word. It waits for the done flag before it changes any field. The one exception is the abort test, which clears the enable bit in mid-word and changes nothing else. MISO comes from a loopback of MOSI, optionally inverted, so MISO changes only when MOSI does, which is on the edge opposite the sampling edge.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_DIV = 3'd1, A_SSEL = 3'd2, A_STAT = 3'd3,
    A_RXC  = 3'd4, A_TXC = 3'd5, A_TXD  = 3'd6, A_RXD  = 3'd7
  } addr_e;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_32B = 2'd3} size_e;

  typedef struct packed {
    size_e size;
    logic  lsbf;
    logic  cpha;
    logic  cpol;
  } cfg_t;

  function automatic logic [5:0] size_bits(size_e s);
    case (s)
      SZ_8:    return 6'd8;
      SZ_16:   return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  // position in the word of the k-th bit on the wire
  function automatic logic [4:0] bit_pos(logic [5:0] k, logic [5:0] n, logic lsbf);
    return 5'(lsbf ? k : (n - 6'd1 - k));
  endfunction
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= wdata_i;
        wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      end
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o) else $error("push on full queue grew it"); // R9
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o) else $error("pop on empty queue changed it"); // R7
endmodule

// File: rtl/spi_shift.sv
`timescale 1ns/1ps
module spi_shift import spi_pkg::*; #(
  parameter int W     = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [W-1:0]     word_i,
  input  cfg_t             cfg_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [W-1:0]     rx_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] per_n, per_q, half_q, pc_q;
  logic [5:0]    k_q, n_q, n_start;
  logic [W-1:0]  tx_q, rx_q;
  cfg_t          cfg_q;
  logic          busy_q, done_q, ph_q, mosi_q;
  logic          lead_edge, trail_edge, last_bit;

  assign per_n      = (div_i == '0) ? PW'(2) : PW'(div_i) + PW'(1);
  assign n_q        = size_bits(cfg_q.size);
  assign n_start    = size_bits(cfg_i.size);
  assign lead_edge  = busy_q && (pc_q == half_q - PW'(1));
  assign trail_edge = busy_q && (pc_q == per_q - PW'(1));
  assign last_bit   = (k_q == n_q - 6'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= 1'b0;
      pc_q   <= '0;
      per_q  <= PW'(2);
      half_q <= PW'(1);
      k_q    <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
      cfg_q  <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cfg_q  <= cfg_i;
          per_q  <= per_n;
          half_q <= per_n >> 1;
          pc_q   <= '0;
          k_q    <= '0;
          tx_q   <= word_i;
          rx_q   <= '0;
          ph_q   <= 1'b0;
          if (!cfg_i.cpha) mosi_q <= word_i[bit_pos(6'd0, n_start, cfg_i.lsbf)];
        end
      end else begin
        pc_q <= pc_q + PW'(1);
        if (lead_edge) begin
          ph_q <= 1'b1;
          if (cfg_q.cpha) mosi_q <= tx_q[bit_pos(k_q, n_q, cfg_q.lsbf)];
          else            rx_q[bit_pos(k_q, n_q, cfg_q.lsbf)] <= miso_i;
        end
        if (trail_edge) begin
          ph_q <= 1'b0;
          pc_q <= '0;
          if (cfg_q.cpha) rx_q[bit_pos(k_q, n_q, cfg_q.lsbf)] <= miso_i;
          else if (!last_bit) mosi_q <= tx_q[bit_pos(6'(k_q + 6'd1), n_q, cfg_q.lsbf)];
          if (last_bit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            k_q <= k_q + 6'd1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign mosi_o = mosi_q;
  assign sclk_o = (busy_q ? cfg_q.cpol : cfg_i.cpol) ^ ph_q;

  AST_RX_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && cfg_q.size == SZ_8) |-> (rx_q[W-1:8] == '0)) else $error("8-bit word not zero-extended"); // R4
endmodule

// File: rtl/spi_reg_master.sv
`timescale 1ns/1ps
module spi_reg_master import spi_pkg::*; #(
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 16,
  parameter int NUM_SS     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  output logic [NUM_SS-1:0] ss_oe_o
);
  localparam int DW = 32;
  localparam int CB_EN = 0, CB_MSTR = 1, CB_CPOL = 2, CB_CPHA = 3, CB_LSBF = 4;

  logic [6:0]        ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_SS-1:0] ss_en_q, ss_lvl_q;
  logic              rxc_q, done_q, ovf_q;
  logic [1:0]        txc_q;
  logic [31:0]       ssel_rd;
  cfg_t              cfg;

  logic          txd_wr, stat_wr, rxd_rd, start;
  logic [DW-1:0] tx_word, rx_word, eng_rx;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          eng_busy, eng_done;

  assign cfg     = '{size: size_e'(ctrl_q[6:5]), lsbf: ctrl_q[CB_LSBF],
                     cpha: ctrl_q[CB_CPHA], cpol: ctrl_q[CB_CPOL]};
  assign txd_wr  = reg_we_i && (addr_e'(reg_addr_i) == A_TXD);
  assign stat_wr = reg_we_i && (addr_e'(reg_addr_i) == A_STAT);
  assign rxd_rd  = reg_re_i && (addr_e'(reg_addr_i) == A_RXD);
  assign start   = ctrl_q[CB_EN] && ctrl_q[CB_MSTR] && rxc_q && (txc_q == 2'b11) &&
                   !tx_empty && !rx_full && !eng_busy && !eng_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      ss_en_q  <= '0;
      ss_lvl_q <= '1;
      rxc_q    <= 1'b0;
      txc_q    <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (addr_e'(reg_addr_i))
          A_CTRL: ctrl_q <= reg_wdata_i[6:0];
          A_DIV:  div_q  <= reg_wdata_i[DIV_W-1:0];
          A_SSEL: begin
            ss_en_q  <= reg_wdata_i[NUM_SS:1];
            ss_lvl_q <= reg_wdata_i[8+NUM_SS:9];
          end
          A_RXC:  rxc_q <= reg_wdata_i[0];
          A_TXC:  txc_q <= reg_wdata_i[1:0];
          default: ;
        endcase
      end
      if (eng_done)                         done_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[1])   done_q <= 1'b0;
      if (txd_wr && tx_full)                ovf_q  <= 1'b1;
      else if (stat_wr && reg_wdata_i[2])   ovf_q  <= 1'b0;
    end
  end

  always_comb begin
    ssel_rd = '0;
    for (int i = 0; i < NUM_SS; i++) begin
      ssel_rd[1+i] = ss_en_q[i];
      ssel_rd[9+i] = ss_lvl_q[i];
    end
  end

  always_comb begin
    case (addr_e'(reg_addr_i))
      A_CTRL:  reg_rdata_o = 32'(ctrl_q);
      A_DIV:   reg_rdata_o = 32'(div_q);
      A_SSEL:  reg_rdata_o = ssel_rd;
      A_STAT:  reg_rdata_o = {29'd0, ovf_q, done_q, rx_empty};
      A_RXC:   reg_rdata_o = 32'(rxc_q);
      A_TXC:   reg_rdata_o = 32'(txc_q);
      A_RXD:   reg_rdata_o = rx_word;
      default: reg_rdata_o = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign ss_no[i] = ss_en_q[i] ? ss_lvl_q[i] : 1'b1;
  end
  assign ss_oe_o = ss_en_q;

  spi_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .push_i(txd_wr), .wdata_i(reg_wdata_i), .pop_i(start),
    .rdata_o(tx_word), .full_o(tx_full), .empty_o(tx_empty));

  spi_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(eng_done), .wdata_i(eng_rx), .pop_i(rxd_rd),
    .rdata_o(rx_word), .full_o(rx_full), .empty_o(rx_empty));

  spi_shift #(.W(DW), .DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni, .en_i(ctrl_q[CB_EN]), .start_i(start), .word_i(tx_word),
    .cfg_i(cfg), .div_i(div_q), .miso_i, .busy_o(eng_busy), .done_o(eng_done),
    .rx_o(eng_rx), .sclk_o, .mosi_o);

  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy |-> (sclk_o == ctrl_q[CB_CPOL])) else $error("sclk off rest level while idle"); // R2
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(stat_wr && reg_wdata_i[1])) |=> done_q) else $error("done flag lost"); // R8
  AST_SS_DISABLED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(ss_no | ss_oe_o)) else $error("disabled select line low"); // R10
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CB_EN] |=> (!eng_busy && !eng_done)) else $error("engine ran while disabled"); // R11
endmodule

// File: tb/spi_reg_master_tb.sv
`timescale 1ns/1ps
module spi_reg_master_tb;
  localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_SSEL = 3'd2, A_STAT = 3'd3,
                         A_RXC = 3'd4, A_TXC = 3'd5, A_TXD = 3'd6, A_RXD = 3'd7;
  // {size[1:0], cpol, cpha, lsbf, inv, div[7:0], data[31:0], exp_rx[31:0]}
  localparam int NV = 6;
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 32'h1234_56A5, 32'h0000_00A5},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 32'h0000_003C, 32'h0000_00C3},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 32'hFFFF_BEEF, 32'h0000_BEEF},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd3, 32'h0000_1234, 32'h0000_EDCB},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd4, 32'h0F0F_1234, 32'hF0F0_EDCB}
  };

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi, miso, inv = 1'b0;
  logic [6:0] ss_n, ss_oe;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_reg_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .ss_no(ss_n), .ss_oe_o(ss_oe));

  // serial monitor: captures MOSI on the sampling edge, times rising edges
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  logic [31:0] mon_sr = '0;
  time t_prev = 0, t_last = 0;
  always @(sclk) begin
    if (sclk === 1'b1) begin
      t_prev = t_last;
      t_last = $time;
    end
    if (sclk === (m_cpol ~^ m_cpha)) mon_sr = {mon_sr[30:0], mosi};
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      rd(A_STAT, s);
      if (s[1]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] rev_bits(input logic [31:0] d, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = d[i];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, got;
    logic ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_SSEL, s);  chk("R1 ssel reset", s, 32'h0000_FE00);
    chk("R1 R10 ss_no reset", 32'(ss_n), 32'h7F);
    chk("R1 R10 ss_oe reset", 32'(ss_oe), 32'h0);
    rd(A_STAT, s);  chk("R1 R8 status reset", s, 32'h1);
    chk("R1 sclk reset", 32'(sclk), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      int n, per;
      logic [31:0] mask, exp_mon;
      v = VEC[i];
      n = (v[77:76] == 2'd0) ? 8 : (v[77:76] == 2'd1) ? 16 : 32;
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
      exp_mon = v[73] ? rev_bits(v[63:32], n) : (v[63:32] & mask);
      per = ((v[71:64] == 8'd0) ? 2 : int'(v[71:64]) + 1) * 5;
      m_cpol = v[75]; m_cpha = v[74]; inv = v[72];
      wr(A_DIV, 32'(v[71:64]));
      wr(A_CTRL, {25'd0, v[77:76], v[73], v[74], v[75], 1'b1, 1'b1});
      wr(A_RXC, 32'd1);
      wr(A_TXC, 32'd3);
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_TXD, v[63:32]);
      wait_done(ok);
      chk("R8 done flag set", 32'(ok), 32'd1);
      rd(A_RXD, got);
      chk("R4 R6 R7 received word", got, v[31:0]);
      chk("R5 R6 serial bit order", mon_sr & mask, exp_mon);
      chk("R2 sclk period", 32'(t_last - t_prev), 32'(per));
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, s);
      chk("R8 write-one clears done", s, 32'h1);
    end
    chk("R2 sclk rests at polarity 1", 32'(sclk), 32'h1);

    rd(A_RXD, got);
    chk("R7 empty read returns zero", got, 32'h0);

    // gating and overflow: 8-bit, mode 0, no inversion
    inv = 1'b0; m_cpol = 1'b0; m_cpha = 1'b0;
    wr(A_DIV, 32'd1);
    wr(A_CTRL, 32'h03);
    wr(A_TXC, 32'd0);
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33); wr(A_TXD, 32'h44);
    wr(A_TXD, 32'h55);
    repeat (100) @(negedge clk);
    rd(A_STAT, s);
    chk("R3 R9 held while transmit off, overflow set", s, 32'h5);
    wr(A_TXC, 32'd3);
    repeat (300) @(negedge clk);
    rd(A_RXD, got); chk("R9 order word 1", got, 32'h11);
    rd(A_RXD, got); chk("R9 order word 2", got, 32'h22);
    rd(A_RXD, got); chk("R9 order word 3", got, 32'h33);
    rd(A_RXD, got); chk("R9 order word 4", got, 32'h44);
    rd(A_RXD, got); chk("R9 dropped fifth word", got, 32'h0);
    rd(A_STAT, s);  chk("R8 R9 sticky flags", s, 32'h7);
    wr(A_STAT, 32'h4);
    rd(A_STAT, s);  chk("R8 clear only overflow", s, 32'h3);

    // master bit gating
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h01);
    wr(A_TXD, 32'h66);
    repeat (100) @(negedge clk);
    rd(A_STAT, s);  chk("R3 no transfer without master bit", s, 32'h1);
    wr(A_CTRL, 32'h03);
    wait_done(ok);
    rd(A_RXD, got); chk("R3 queued word sent once enabled", got, 32'h66);

    // abort in mid-word
    wr(A_STAT, 32'hFFFF_FFFF);
    m_cpol = 1'b1;
    wr(A_DIV, 32'd4);
    wr(A_CTRL, 32'h47);
    wr(A_TXD, 32'hCAFE_F00D);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h46);
    @(negedge clk);
    chk("R11 R2 sclk back to rest after abort", 32'(sclk), 32'h1);
    repeat (300) @(negedge clk);
    rd(A_STAT, s);  chk("R11 no word or done after abort", s, 32'h1);

    // slave select fields
    wr(A_SSEL, 32'h0000_F20A);
    chk("R10 select enables", 32'(ss_oe), 32'h05);
    chk("R10 select levels, disabled line high", 32'(ss_n), 32'h7B);
    rd(A_SSEL, s);  chk("R10 select readback", s, 32'h0000_F20A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule